// File: doc/BRIEF.md
# Program status word register unit

This block holds the 64-bit status word of a processor. The word packs eight interrupt mask bits, a problem-state flag, a two-bit condition code, an addressing-mode flag and a 31-bit instruction address. Software with privilege replaces the whole word through a load port. The current word is always visible on a read-out port. ALU results update the condition code. The sequencer advances the instruction address by 2, 4 or 6 bytes.

A branch unit supplies a four-bit mask, and the block answers straight away whether the branch is taken under the current condition code. When a full-word load is attempted from problem state, the block refuses it and raises a one-cycle fault so that the exception logic can respond.

Bits in this description are numbered with 0 as the most significant bit of the word. Field bit n therefore sits at vector index 63-n on `psw_o` and `load_word_i`.

Top module: `psw_unit`

## Requirements
- R1: An asynchronous active-low reset clears the whole word to zero: privileged, all interrupts masked, 24-bit mode, address 0, no fault.
- R2: The word fields are laid out as follows. Interrupt masks are bits 0-7 (index 63:56). The problem flag is bit 15 (index 48, 1 = unprivileged). The condition code is bits 18-19 (index 45:44). The addressing mode is bit 32 (index 31, 1 = 31-bit). The address is bits 33-63 (index 30:0). `cc_o`, `problem_o`, `amode_o` and `addr_o` reflect these fields.
- R3: A load request made with the problem flag at 0 replaces the whole word with `load_word_i` at the next clock edge.
- R4: A load request made with the problem flag at 1 leaves the word unchanged for that cycle. `priv_fault_o` is high for exactly the cycle after the request.
- R5: A condition-code update writes only the condition code and is accepted in either privilege state.
- R6: When a load request meets a condition-code update or an address advance in the same cycle, the load decides the outcome and the other updates are dropped.
- R7: `br_taken_o` is mask bit 3 when the code is 0, bit 2 for code 1, bit 1 for code 2 and bit 0 for code 3.
- R8: Mask 15 always gives a taken branch and mask 0 never does.
- R9: In 31-bit mode an advance of 2, 4 or 6 bytes (`adv_len_i` = 1, 2, 3 halfwords) wraps the address modulo 2^31.
- R10: In 24-bit mode an advance wraps modulo 2^24 and writes zeros to address bits 24-30 (index 30:24).
- R11: With no request present, the word holds its value, and reading `psw_o` never changes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| load_req_i | input | 1 | Full-word load request |
| load_word_i | input | 64 | Word to load |
| cc_we_i | input | 1 | Condition-code update strobe |
| cc_i | input | 2 | New condition code |
| adv_i | input | 1 | Instruction-address advance strobe |
| adv_len_i | input | 2 | Advance length in halfwords (1..3) |
| br_mask_i | input | 4 | Branch test mask |
| psw_o | output | 64 | Current word (read-out) |
| cc_o | output | 2 | Current condition code |
| problem_o | output | 1 | Problem-state flag |
| amode_o | output | 1 | Addressing-mode flag |
| addr_o | output | 31 | Instruction address |
| br_taken_o | output | 1 | Branch decision |
| priv_fault_o | output | 1 | Rejected privileged load pulse |

## Verification
On every cycle the assertions check the following. An accepted load installs the whole word. A rejected load freezes it, and each fault traces back to a rejected request. A code update lands when no load competes, and the load wins when one does. An idle cycle holds the word, a 24-bit advance leaves the upper address bits clear, and the all-ones and all-zeros masks decide the branch. Only the bench scenarios show the wrap values at the 2^24 and 2^31 limits. They also show the exact mask-bit-to-code pairing over a table of code and mask combinations, the one-cycle width of the fault pulse, and that a code update still works in problem state.

// File: rtl/psw_pkg.sv
package psw_pkg;
  localparam int unsigned WORD_W  = 64;
  localparam int unsigned ADDR_W  = 31;
  localparam int unsigned SHORT_W = 24;
  localparam int unsigned CC_W    = 2;
  localparam int unsigned MASK_W  = 1 << CC_W;
  localparam int unsigned IRQ_W   = 8;
  localparam int unsigned LEN_W   = 2;

  // field bit n (0 = MSB) lives at vector index WORD_W-1-n
  localparam int unsigned IRQ_HI    = WORD_W - 1;
  localparam int unsigned IRQ_LO    = WORD_W - IRQ_W;
  localparam int unsigned PROB_BIT  = WORD_W - 1 - 15;
  localparam int unsigned CC_HI     = WORD_W - 1 - 18;
  localparam int unsigned CC_LO     = WORD_W - 1 - 19;
  localparam int unsigned AMODE_BIT = WORD_W - 1 - 32;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [CC_W-1:0]   cc_t;
endpackage

// File: rtl/psw_branch_test.sv
module psw_branch_test
  import psw_pkg::*;
(
  input  cc_t              cc_i,
  input  logic [MASK_W-1:0] mask_i,
  output logic             taken_o
);
  logic [MASK_W-1:0] code_hot;

  // mask bit MASK_W-1 pairs with code 0
  for (genvar g = 0; g < MASK_W; g++) begin : g_dec
    assign code_hot[MASK_W-1-g] = (cc_i == CC_W'(g));
  end

  assign taken_o = |(code_hot & mask_i);
endmodule

// File: rtl/psw_addr_step.sv
module psw_addr_step
  import psw_pkg::*;
(
  input  addr_t            addr_i,
  input  logic             wide_i,
  input  logic [LEN_W-1:0] len_i,
  output addr_t            addr_o
);
  localparam int unsigned HI_W = ADDR_W - SHORT_W;

  addr_t               inc;
  logic [SHORT_W-1:0]  short_sum;
  addr_t               wide_sum;

  assign inc       = addr_t'({len_i, 1'b0});
  assign wide_sum  = addr_i + inc;
  assign short_sum = addr_i[SHORT_W-1:0] + inc[SHORT_W-1:0];
  assign addr_o    = wide_i ? wide_sum : {{HI_W{1'b0}}, short_sum};
endmodule

// File: rtl/psw_load_guard.sv
module psw_load_guard (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic problem_i,
  output logic accept_o,
  output logic fault_o
);
  assign accept_o = req_i & ~problem_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fault_o <= 1'b0;
    else         fault_o <= req_i & problem_i;
  end

  assert_fault_cause_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> $past(req_i && problem_i));
endmodule

// File: rtl/psw_unit.sv
module psw_unit
  import psw_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_req_i,
  input  logic [WORD_W-1:0] load_word_i,
  input  logic              cc_we_i,
  input  logic [CC_W-1:0]   cc_i,
  input  logic              adv_i,
  input  logic [LEN_W-1:0]  adv_len_i,
  input  logic [MASK_W-1:0] br_mask_i,
  output logic [WORD_W-1:0] psw_o,
  output logic [CC_W-1:0]   cc_o,
  output logic              problem_o,
  output logic              amode_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              br_taken_o,
  output logic              priv_fault_o
);
  word_t psw_q;
  addr_t addr_next;
  logic  load_ok;

  psw_load_guard u_guard (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (load_req_i),
    .problem_i (psw_q[PROB_BIT]),
    .accept_o  (load_ok),
    .fault_o   (priv_fault_o)
  );

  psw_addr_step u_step (
    .addr_i (psw_q[ADDR_W-1:0]),
    .wide_i (psw_q[AMODE_BIT]),
    .len_i  (adv_len_i),
    .addr_o (addr_next)
  );

  psw_branch_test u_br (
    .cc_i    (psw_q[CC_HI:CC_LO]),
    .mask_i  (br_mask_i),
    .taken_o (br_taken_o)
  );

  // any load request, accepted or refused, blocks the partial updates
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      psw_q <= '0;
    end else if (load_ok) begin
      psw_q <= load_word_i;
    end else if (!load_req_i) begin
      if (cc_we_i) psw_q[CC_HI:CC_LO]  <= cc_i;
      if (adv_i)   psw_q[ADDR_W-1:0]   <= addr_next;
    end
  end

  assign psw_o     = psw_q;
  assign cc_o      = psw_q[CC_HI:CC_LO];
  assign problem_o = psw_q[PROB_BIT];
  assign amode_o   = psw_q[AMODE_BIT];
  assign addr_o    = psw_q[ADDR_W-1:0];

  assert_load_whole_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_req_i && !problem_o) |=> (psw_o == $past(load_word_i)));

  assert_reject_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_req_i && problem_o) |=> $stable(psw_o));

  assert_cc_write_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cc_we_i && !load_req_i) |=> (cc_o == $past(cc_i)));

  assert_load_first_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_req_i && !problem_o && cc_we_i) |=> (cc_o == $past(load_word_i[CC_HI:CC_LO])));

  assert_mask_all_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (br_mask_i == '1) |-> br_taken_o);

  assert_mask_none_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (br_mask_i == '0) |-> !br_taken_o);

  assert_short_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !load_req_i && !amode_o) |=> (addr_o[ADDR_W-1:SHORT_W] == '0));

  assert_idle_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_req_i && !cc_we_i && !adv_i) |=> $stable(psw_o));
endmodule

// File: tb/psw_unit_test.sv
module psw_unit_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        load_req_i = 1'b0;
  logic [63:0] load_word_i = '0;
  logic        cc_we_i = 1'b0;
  logic [1:0]  cc_i = '0;
  logic        adv_i = 1'b0;
  logic [1:0]  adv_len_i = '0;
  logic [3:0]  br_mask_i = '0;
  logic [63:0] psw_o;
  logic [1:0]  cc_o;
  logic        problem_o, amode_o, br_taken_o, priv_fault_o;
  logic [30:0] addr_o;

  int n_run = 0;
  int n_fail = 0;

  // {cc[1:0], mask[3:0], expected taken}
  localparam logic [6:0] BR_VEC [10] = '{
    {2'd0, 4'b1000, 1'b1}, {2'd0, 4'b0111, 1'b0},
    {2'd1, 4'b0100, 1'b1}, {2'd1, 4'b1011, 1'b0},
    {2'd2, 4'b0010, 1'b1}, {2'd2, 4'b1101, 1'b0},
    {2'd3, 4'b0001, 1'b1}, {2'd3, 4'b1110, 1'b0},
    {2'd2, 4'b1111, 1'b1}, {2'd1, 4'b0000, 1'b0}
  };

  always #(CLK_PERIOD/2) clk = ~clk;

  psw_unit uut (
    .clk_i(clk), .rst_ni(rst_ni), .load_req_i(load_req_i), .load_word_i(load_word_i),
    .cc_we_i(cc_we_i), .cc_i(cc_i), .adv_i(adv_i), .adv_len_i(adv_len_i),
    .br_mask_i(br_mask_i), .psw_o(psw_o), .cc_o(cc_o), .problem_o(problem_o),
    .amode_o(amode_o), .addr_o(addr_o), .br_taken_o(br_taken_o),
    .priv_fault_o(priv_fault_o)
  );

  function automatic logic [63:0] mk(logic [7:0] irq, logic prob, logic [1:0] cc,
                                     logic am, logic [30:0] addr);
    return {irq, 7'd0, prob, 2'd0, cc, 12'd0, am, addr};
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  task automatic load(input logic [63:0] w);
    load_req_i = 1'b1; load_word_i = w;
    tick();
    load_req_i = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_run++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [63:0] w, held;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_ni = 1'b1;
    #1;
    chk("R1 word after reset", psw_o, 64'd0);
    chk("R1 fault after reset", {63'd0, priv_fault_o}, 64'd0);

    // R7 R8 branch table
    for (int i = 0; i < 10; i++) begin
      cc_we_i = 1'b1; cc_i = BR_VEC[i][6:5];
      tick();
      cc_we_i = 1'b0;
      br_mask_i = BR_VEC[i][4:1];
      #1;
      chk($sformatf("R7 R8 branch vec %0d", i), {63'd0, br_taken_o}, {63'd0, BR_VEC[i][0]});
    end
    br_mask_i = '0;

    // R3 R2 full load, 31-bit mode near the top
    w = mk(8'hA5, 1'b0, 2'd2, 1'b1, 31'h7FFF_FFFC);
    load(w);
    chk("R3 load whole word", psw_o, w);
    chk("R2 cc field", {62'd0, cc_o}, 64'd2);
    chk("R2 amode field", {63'd0, amode_o}, 64'd1);
    chk("R2 addr field", {33'd0, addr_o}, 64'h7FFF_FFFC);

    // R9 wrap at 2^31
    adv_i = 1'b1; adv_len_i = 2'd3;
    tick();
    adv_i = 1'b0;
    chk("R9 31-bit wrap", {33'd0, addr_o}, 64'd2);
    chk("R9 other fields kept", psw_o[63:31], w[63:31]);

    // R10 wrap at 2^24 with upper bits cleared
    load(mk(8'h00, 1'b0, 2'd0, 1'b0, 31'h7FFF_FFFE));
    adv_i = 1'b1; adv_len_i = 2'd2;
    tick();
    adv_i = 1'b0;
    chk("R10 24-bit wrap", {33'd0, addr_o}, 64'd2);
    load(mk(8'h00, 1'b0, 2'd0, 1'b0, 31'h7F00_0010));
    adv_i = 1'b1; adv_len_i = 2'd1;
    tick();
    adv_i = 1'b0;
    chk("R10 upper bits forced zero", {33'd0, addr_o}, 64'h12);

    // R6 load beats cc update and advance
    w = mk(8'h3C, 1'b0, 2'd1, 1'b1, 31'h100);
    cc_we_i = 1'b1; cc_i = 2'd2; adv_i = 1'b1; adv_len_i = 2'd3;
    load(w);
    cc_we_i = 1'b0; adv_i = 1'b0;
    chk("R6 load priority", psw_o, w);

    // R11 idle hold
    held = psw_o;
    repeat (3) tick();
    chk("R11 idle hold", psw_o, held);

    // R4 enter problem state, then refused load
    w = mk(8'hFF, 1'b1, 2'd0, 1'b1, 31'h200);
    load(w);
    chk("R4 problem flag set", {63'd0, problem_o}, 64'd1);
    load(mk(8'h00, 1'b0, 2'd3, 1'b0, 31'h0));
    chk("R4 word unchanged", psw_o, w);
    chk("R4 fault raised", {63'd0, priv_fault_o}, 64'd1);
    tick();
    chk("R4 fault one cycle", {63'd0, priv_fault_o}, 64'd0);

    // R5 cc update in problem state touches only cc
    cc_we_i = 1'b1; cc_i = 2'd3;
    tick();
    cc_we_i = 1'b0;
    chk("R5 cc update unprivileged", psw_o, mk(8'hFF, 1'b1, 2'd3, 1'b1, 31'h200));

    // R1 reset mid-run
    rst_ni = 1'b0;
    #1;
    chk("R1 async reset", psw_o, 64'd0);
    @(negedge clk); rst_ni = 1'b1;

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule